// File: doc/BRIEF.md
# Two-Port Banked Interleaved Data Array

The block is a data array made of eight single-ported banks that two access ports share through a crossbar. Each port may present a read or a write every cycle. A bank number is derived from the port's address under a run-time interleave choice. In fine mode the lowest address bits select the bank, so consecutive words spread across all banks. In coarse mode the highest address bits select the bank, so each bank holds one contiguous region. When the two ports land in different banks, both accesses are carried out in the same cycle.

When both ports target the same bank, port 0 always wins. Port 1 is told in that same cycle, through a replay flag, that its access was dropped and must be reissued. A requester treats this flag like a miss. Two reads of the very same word do not collide, and both are answered. Read data comes back on the requesting port one cycle after the request, marked by a valid flag. Tag lookup and miss handling sit outside this block.

Top module: `banked_dual_port_array`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both read-valid outputs are low. The replay flag is low whenever no request is present.
- R2: With `coarse_mode`=0, the bank is `addr[2:0]` and the word within the bank is `addr[ADDR_W-1:3]`. The physical location is {addr[2:0], addr[ADDR_W-1:3]}.
- R3: With `coarse_mode`=1, the bank is `addr[ADDR_W-1:ADDR_W-3]` and the word within the bank is `addr[ADDR_W-4:0]`. The physical location is the address itself. A word written in one mode is therefore read back in the other mode at the remapped address.
- R4: Two requests to different banks are both carried out in the same cycle. This holds for any mix of reads and writes.
- R5: Two requests to the same bank raise `p1_replay` combinationally in the request cycle. Port 0 is served. The port 1 access has no effect: a dropped write leaves the memory unchanged, and a dropped read produces no `p1_rvalid`.
- R6: Two reads of the identical address never raise `p1_replay`. Both ports return the same word.
- R7: A read accepted in cycle N drives its port's `rvalid` high with the stored word on `rdata` in cycle N+1. Writes and idle cycles leave `rvalid` low in the following cycle.
- R8: A write on one port and a read on the other, to different banks, both complete in the same cycle. The read returns the contents from before that cycle's write.
- R9: `p1_replay` is raised only when both ports request in the same cycle. A lone port 1 request is always served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 0: bank taken from low address bits; 1: bank taken from high address bits |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_replay | output | 1 | Port 1 lost a bank conflict this cycle; reissue the access |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DATA_W | Port 1 read data |

## Verification
The replay flag is combinational, so the bench samples it one nanosecond after driving the inputs, still inside the request cycle. Read valid and read data come from one register stage, so they are sampled at the next falling edge, exactly one cycle after the request. The bench applies its reference-memory update only after that sample, which matches the read-before-write ordering of R8. Expected read data comes from a bench model that uses the physical mapping stated in R2 and R3, and that model skips every port 1 write the requirements say is dropped.

// File: rtl/banked_dual_port_array.sv
module banked_dual_port_array #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int BANK_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coarse_mode,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_replay,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] to_phys(input logic cm, input logic [ADDR_W-1:0] a);
    return cm ? a : {a[BANK_BITS-1:0], a[ADDR_W-1:BANK_BITS]};
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] loc0, loc1;
  logic [BANK_BITS-1:0] bank0, bank1;
  logic same_word_rd, p1_go;

  assign loc0  = to_phys(coarse_mode, p0_addr);
  assign loc1  = to_phys(coarse_mode, p1_addr);
  assign bank0 = loc0[ADDR_W-1 -: BANK_BITS];
  assign bank1 = loc1[ADDR_W-1 -: BANK_BITS];

  assign same_word_rd = !p0_we && !p1_we && (p0_addr == p1_addr);
  assign p1_replay    = p0_req && p1_req && (bank0 == bank1) && !same_word_rd;
  assign p1_go        = p1_req && !p1_replay;

  always_ff @(posedge clk) begin
    if (p0_req && p0_we) mem[loc0] <= p0_wdata;
    if (p1_go && p1_we)  mem[loc1] <= p1_wdata;
    if (p0_req && !p0_we) p0_rdata <= mem[loc0];
    if (p1_go && !p1_we)  p1_rdata <= mem[loc1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_rvalid <= 1'b0;
      p1_rvalid <= 1'b0;
    end else begin
      p0_rvalid <= p0_req && !p0_we;
      p1_rvalid <= p1_go && !p1_we;
    end
  end

  AST_REPLAY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    p1_replay |-> (p0_req && p1_req)); // R9
  AST_REPLAY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    p1_replay |=> !p1_rvalid); // R5
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && !p0_we) |=> p0_rvalid); // R7
  AST_SAME_WORD_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p1_req && !p0_we && !p1_we && p0_addr == p1_addr) |-> !p1_replay); // R6
  AST_SAME_WORD_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p1_req && !p0_we && !p1_we && p0_addr == p1_addr) |=> (p1_rvalid && p0_rdata == p1_rdata)); // R6
  AST_FINE_SPLIT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && p1_req && p0_addr[BANK_BITS-1:0] != p1_addr[BANK_BITS-1:0]) |-> !p1_replay); // R2
  AST_COARSE_SPLIT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && p1_req && p0_addr[ADDR_W-1 -: BANK_BITS] != p1_addr[ADDR_W-1 -: BANK_BITS]) |-> !p1_replay); // R3
  AST_IDLE_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_req |-> !p1_replay); // R1
endmodule

// File: tb/sim_banked_dual_port_array.sv
`timescale 1ns/1ps
module sim_banked_dual_port_array;
  logic clk = 1'b0, rst_n = 1'b0, coarse_mode = 1'b0;
  logic p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
  logic [9:0] p0_addr = '0, p1_addr = '0;
  logic [15:0] p0_wdata = '0, p1_wdata = '0;
  logic p1_replay, p0_rvalid, p1_rvalid;
  logic [15:0] p0_rdata, p1_rdata;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [15:0] mdl [1024];

  always #2.5 clk = ~clk;

  banked_dual_port_array u0 (.clk, .rst_n, .coarse_mode, .p0_req, .p0_we, .p0_addr, .p0_wdata,
    .p1_req, .p1_we, .p1_addr, .p1_wdata, .p1_replay, .p0_rvalid, .p0_rdata, .p1_rvalid, .p1_rdata);

  typedef struct packed {
    logic cm; logic r0; logic w0; logic [9:0] a0; logic [15:0] d0;
    logic r1; logic w1; logic [9:0] a1; logic [15:0] d1; logic xr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,10'h020,16'h1111, 1'b0,1'b0,10'h000,16'h0000, 1'b0}, // R2 prefill
    '{1'b0,1'b1,1'b1,10'h010,16'hA001, 1'b1,1'b1,10'h011,16'hB001, 1'b0}, // R4 write/write
    '{1'b0,1'b1,1'b0,10'h011,16'h0000, 1'b1,1'b0,10'h010,16'h0000, 1'b0}, // R4 read/read
    '{1'b0,1'b1,1'b1,10'h018,16'hC0C0, 1'b1,1'b1,10'h020,16'hD0D0, 1'b1}, // R5 write conflict
    '{1'b0,1'b1,1'b0,10'h018,16'h0000, 1'b1,1'b0,10'h011,16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,10'h020,16'h0000, 1'b0,1'b0,10'h000,16'h0000, 1'b0}, // R5 dropped write
    '{1'b0,1'b1,1'b0,10'h010,16'h0000, 1'b1,1'b0,10'h010,16'h0000, 1'b0}, // R6 same word
    '{1'b0,1'b1,1'b0,10'h010,16'h0000, 1'b1,1'b0,10'h018,16'h0000, 1'b1}, // R5 read conflict
    '{1'b0,1'b1,1'b1,10'h012,16'h2222, 1'b1,1'b0,10'h011,16'h0000, 1'b0}, // R8
    '{1'b0,1'b1,1'b0,10'h011,16'h0000, 1'b1,1'b1,10'h013,16'h3333, 1'b0}, // R8
    '{1'b0,1'b0,1'b0,10'h013,16'h0000, 1'b1,1'b0,10'h013,16'h0000, 1'b0}, // R9 lone p1
    '{1'b0,1'b1,1'b1,10'h012,16'h9999, 1'b1,1'b0,10'h012,16'h0000, 1'b1}, // R5 write vs read
    '{1'b1,1'b1,1'b0,10'h082,16'h0000, 1'b1,1'b0,10'h002,16'h0000, 1'b0}, // R3 remapped read
    '{1'b1,1'b1,1'b1,10'h001,16'h4444, 1'b1,1'b1,10'h081,16'h5555, 1'b0}, // R3 R4
    '{1'b1,1'b1,1'b1,10'h00D,16'h8888, 1'b0,1'b0,10'h000,16'h0000, 1'b0},
    '{1'b1,1'b1,1'b1,10'h005,16'h6666, 1'b1,1'b1,10'h00D,16'h7777, 1'b1}, // R3 R5
    '{1'b1,1'b1,1'b0,10'h081,16'h0000, 1'b1,1'b0,10'h001,16'h0000, 1'b0},
    '{1'b1,1'b1,1'b0,10'h00D,16'h0000, 1'b1,1'b0,10'h005,16'h0000, 1'b1}  // R5
  };

  function automatic int loc(input logic cm, input logic [9:0] a);
    return cm ? int'(a) : int'({a[2:0], a[9:3]});
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    logic e0v, e1v;
    logic [15:0] e0d, e1d;
    coarse_mode = v.cm;
    p0_req = v.r0; p0_we = v.w0; p0_addr = v.a0; p0_wdata = v.d0;
    p1_req = v.r1; p1_we = v.w1; p1_addr = v.a1; p1_wdata = v.d1;
    #1;
    chk("R5 replay", {31'd0, p1_replay}, {31'd0, v.xr});
    e0v = v.r0 && !v.w0;
    e1v = v.r1 && !v.w1 && !v.xr;
    e0d = mdl[loc(v.cm, v.a0)];
    e1d = mdl[loc(v.cm, v.a1)];
    @(negedge clk);
    chk("R7 p0_rvalid", {31'd0, p0_rvalid}, {31'd0, e0v});
    chk("R7 p1_rvalid", {31'd0, p1_rvalid}, {31'd0, e1v});
    if (e0v) chk("R4 p0_rdata", {16'd0, p0_rdata}, {16'd0, e0d});
    if (e1v) chk("R4 p1_rdata", {16'd0, p1_rdata}, {16'd0, e1d});
    if (v.r0 && v.w0) mdl[loc(v.cm, v.a0)] = v.d0;
    if (v.r1 && v.w1 && !v.xr) mdl[loc(v.cm, v.a1)] = v.d1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 p0_rvalid in reset", {31'd0, p0_rvalid}, 32'd0);
    chk("R1 p1_rvalid in reset", {31'd0, p1_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 p0_rvalid after reset", {31'd0, p0_rvalid}, 32'd0);
    chk("R1 replay idle", {31'd0, p1_replay}, 32'd0);
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R1: reset during a read suppresses the valid
    coarse_mode = 1'b0; p0_req = 1'b1; p0_we = 1'b0; p0_addr = 10'h010; p1_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rvalid held by reset", {31'd0, p0_rvalid}, 32'd0);
    p0_req = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid idle", {31'd0, p0_rvalid}, 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #(200000 * 5); nchk++; nerr++; $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule